// File: doc/BRIEF.md
# Auto-Reload Up/Down 16-bit Timer

This block is a 16-bit timer that reloads itself when it wraps. It counts steps from one of two sources. The first is an internal tick that fires once every 12 clock cycles, or every 6 in fast mode. The second is an external pin, which is synchronised and counted on its falling edges. The timer advances only while the run input is high.

When direction control is enabled, the level on a direction pin selects the counting direction. Counting up, the timer passes all-ones and then loads the reload value. Counting down, it loads all-ones at the step taken while the count equals the reload value.

Every wrap sets a sticky overflow flag and toggles a parity flag, so the parity flag acts as a 17th count bit. A single clear strobe clears both flags. The reload value is read only at the moment of a wrap, so software can change it at any time without disturbing the running count.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset, `count` is 0000h and both `ovf_flag` and `par_flag` are 0.
- R2: Counting up, each step adds one. A step taken at FFFFh loads `reload_val` instead and counts as a wrap.
- R3: Counting down, each step subtracts one. A step taken while `count` equals `reload_val` loads FFFFh and counts as a wrap. Passing from 0000h to FFFFh when `reload_val` is not 0000h is a plain decrement and not a wrap.
- R4: With `dir_en` = 0 the timer always counts up and `dir_pin` is ignored. With `dir_en` = 1, `dir_pin` = 1 selects up and `dir_pin` = 0 selects down.
- R5: Every wrap sets `ovf_flag`, and the flag stays set until it is cleared.
- R6: Every wrap inverts `par_flag`.
- R7: While `run` = 0, `count` does not change, whatever the count source does.
- R8: With `src_sel` = 0 the step source is internal. After reset release, one step occurs every 12 clocks with `fast_mode` = 0, or every 6 clocks with `fast_mode` = 1. The `ext_pin` input is ignored.
- R9: With `src_sel` = 1, each falling edge on `ext_pin` gives one step. The new count appears at the third rising clock edge after the pin goes low.
- R10: A one-cycle `flag_clr` pulse clears both flags. If a wrap happens in the same cycle as the clear, the wrap wins: `ovf_flag` is set and `par_flag` is inverted.
- R11: `reload_val` is used only at a wrap. Changing it never alters `count` between wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | 0 = internal divided tick, 1 = external pin |
| fast_mode | input | 1 | Internal divider is 6 instead of 12 |
| ext_pin | input | 1 | External count input, asynchronous |
| run | input | 1 | Counting enable |
| dir_en | input | 1 | Enables direction control by `dir_pin` |
| dir_pin | input | 1 | 1 = up, 0 = down, used when `dir_en` = 1 |
| reload_val | input | 16 | Value loaded on an up-count wrap; down-count wrap point |
| flag_clr | input | 1 | Clears both flags |
| ovf_flag | output | 1 | Sticky wrap flag (interrupt request) |
| par_flag | output | 1 | Wrap parity flag |
| count | output | 16 | Current count |

## Verification
The assertions check the following on every cycle:
- the count holds when there is no step;
- single steps add or subtract one;
- the two wrap loads happen at the right points;
- the flags react to a wrap and to a clear;
- the prescaler tick and the falling-edge pulse each last exactly one cycle.

Some behaviours need the bench's scenarios:
- the exact divider ratios;
- the three-edge latency from the external pin to the count;
- the case where the count passes through zero going down without a flag;
- parity across several consecutive wraps;
- a reload value changed between wraps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic { SRC_INTERNAL = 1'b0, SRC_EXTERNAL = 1'b1 } src_e;
  typedef enum logic { DIR_DOWN = 1'b0, DIR_UP = 1'b1 } dir_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW + 1);

  logic [PW-1:0] div_cnt;
  logic [PW-1:0] limit;

  assign limit = fast_mode ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick  = (div_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end

  // R8: the internal tick lasts a single cycle
  assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic sync_a, sync_b, last_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      last_b <= 1'b0;
    end else begin
      sync_a <= pin;
      sync_b <= sync_a;
      last_b <= sync_b;
    end
  end

  assign fall = last_b & ~sync_b;

  // R9: one falling edge gives exactly one pulse
  assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             up,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  // returns {wrap, next count} for one step
  function automatic logic [CNT_W:0] step_fn(input logic [CNT_W-1:0] cur,
                                             input logic go_up,
                                             input logic [CNT_W-1:0] rl);
    if (go_up) begin
      if (cur == ALL_ONES) return {1'b1, rl};
      else                 return {1'b0, cur + 1'b1};
    end else begin
      if (cur == rl)       return {1'b1, ALL_ONES};
      else                 return {1'b0, cur - 1'b1};
    end
  endfunction

  logic [CNT_W:0] nxt;
  assign nxt  = step_fn(count, up, reload);
  assign wrap = adv & nxt[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (adv) count <= nxt[CNT_W-1:0];
  end

  // R7 / R11: no step means no change, whatever the reload input does
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(count));
  // R2: plain up step
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && up && count != ALL_ONES) |=> count == $past(count) + 1'b1);
  // R2: up wrap loads reload
  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && up && count == ALL_ONES) |=> count == $past(reload));
  // R3: down wrap loads all ones
  assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !up && count == reload) |=> count == ALL_ONES);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic clr,
  output logic ovf_flag,
  output logic par_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      par_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
      par_flag <= ~par_flag;
    end else if (clr) begin
      ovf_flag <= 1'b0;
      par_flag <= 1'b0;
    end
  end

  // R5 / R10: a wrap always leaves the overflow flag set
  assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R6: a wrap inverts parity
  assert_wrap_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> par_flag != $past(par_flag));
  // R10: a lone clear empties both flags
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wrap) |=> (!ovf_flag && !par_flag));
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             fast_mode,
  input  logic             ext_pin,
  input  logic             run,
  input  logic             dir_en,
  input  logic             dir_pin,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             flag_clr,
  output logic             ovf_flag,
  output logic             par_flag,
  output logic [CNT_W-1:0] count
);
  import tmr_pkg::*;

  logic int_tick, ext_fall, step_src, adv, wrap;
  dir_e dir;

  tmr_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .tick(int_tick));

  tmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall(ext_fall));

  assign step_src = (src_e'(src_sel) == SRC_EXTERNAL) ? ext_fall : int_tick;
  assign adv      = run & step_src;
  assign dir      = (!dir_en || dir_pin) ? DIR_UP : DIR_DOWN;

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .up(dir == DIR_UP),
    .reload(reload_val), .count(count), .wrap(wrap));

  tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .clr(flag_clr),
    .ovf_flag(ovf_flag), .par_flag(par_flag));

  // R7: a stopped timer keeps its count
  assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  // R4: direction disabled never counts down
  assert_dir_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !dir_en && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1);
endmodule

// File: tb/updown_reload_timer_bench.sv
`timescale 1ns/1ps
module updown_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_sel = 1'b1, fast_mode = 1'b0, ext_pin = 1'b0, run = 1'b1;
  logic        dir_en = 1'b0, dir_pin = 1'b0, flag_clr = 1'b0;
  logic [15:0] reload_val = 16'h0000;
  logic        ovf_flag, par_flag;
  logic [15:0] count;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  updown_reload_timer u_updown_reload_timer (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fast_mode(fast_mode),
    .ext_pin(ext_pin), .run(run), .dir_en(dir_en), .dir_pin(dir_pin),
    .reload_val(reload_val), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .par_flag(par_flag), .count(count));

  typedef struct packed {
    logic        den;
    logic        dpin;
    logic        clr;
    logic [3:0]  pulses;
    logic [15:0] rl;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
    logic        exp_par;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 4'd1, 16'h1234, 16'hFFFF, 1'b0, 1'b0}, // R3 through zero, no flag
    '{1'b1, 1'b1, 1'b0, 4'd1, 16'h1234, 16'h1234, 1'b1, 1'b1}, // R2 up wrap
    '{1'b0, 1'b0, 1'b0, 4'd3, 16'h1234, 16'h1237, 1'b1, 1'b1}, // R4 pin ignored
    '{1'b1, 1'b0, 1'b0, 4'd3, 16'h1234, 16'h1234, 1'b1, 1'b1}, // R3 reach reload
    '{1'b1, 1'b0, 1'b1, 4'd1, 16'h1234, 16'hFFFF, 1'b1, 1'b1}, // R3 down wrap, R10
    '{1'b0, 1'b1, 1'b1, 4'd2, 16'h00F0, 16'h00F1, 1'b1, 1'b1}, // R11 new reload at wrap
    '{1'b0, 1'b1, 1'b1, 4'd0, 16'h00F0, 16'h00F1, 1'b0, 1'b0}, // R10 clear
    '{1'b1, 1'b0, 1'b0, 4'd1, 16'h00F0, 16'h00F0, 1'b0, 1'b0}, // R3
    '{1'b1, 1'b0, 1'b0, 4'd2, 16'h00F0, 16'hFFFE, 1'b1, 1'b1}, // R3 R5 R6
    '{1'b1, 1'b1, 1'b0, 4'd2, 16'hABCD, 16'hABCD, 1'b1, 1'b0}, // R6 parity back
    '{1'b0, 1'b0, 1'b0, 4'd0, 16'h5555, 16'hABCD, 1'b1, 1'b0}  // R11 no effect
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic pulse_ext();
    ext_pin = 1'b1;
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(count, 16'h0000, "R1 count");
    check({15'd0, ovf_flag}, 16'd0, "R1 ovf");
    check({15'd0, par_flag}, 16'd0, "R1 par");

    for (int i = 0; i < NV; i++) begin
      dir_en     = VEC[i].den;
      dir_pin    = VEC[i].dpin;
      reload_val = VEC[i].rl;
      if (VEC[i].clr) strobe_clr();
      for (int p = 0; p < int'(VEC[i].pulses); p++) pulse_ext();
      @(negedge clk);
      check(count, VEC[i].exp_cnt, $sformatf("R2/R3/R4/R11 row %0d count", i));
      check({15'd0, ovf_flag}, {15'd0, VEC[i].exp_ovf}, $sformatf("R5/R10 row %0d ovf", i));
      check({15'd0, par_flag}, {15'd0, VEC[i].exp_par}, $sformatf("R6/R10 row %0d par", i));
    end

    // R10: wrap and clear in the same cycle, the wrap wins
    dir_en = 1'b1; dir_pin = 1'b0; reload_val = 16'hABCD;
    ext_pin = 1'b1;
    repeat (3) @(negedge clk);
    ext_pin = 1'b0; flag_clr = 1'b1;
    repeat (3) @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    check(count, 16'hFFFF, "R3 wrap under clear");
    check({15'd0, ovf_flag}, 16'd1, "R10 set wins ovf");
    check({15'd0, par_flag}, 16'd1, "R10 set wins par");

    // R7: stopped timer ignores steps
    run = 1'b0;
    pulse_ext();
    pulse_ext();
    check(count, 16'hFFFF, "R7 hold");
    run = 1'b1;

    // R9: latency of three edges
    do_reset();
    dir_en = 1'b0;
    ext_pin = 1'b1;
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    check(count, 16'h0000, "R9 before third edge");
    @(negedge clk);
    check(count, 16'h0001, "R9 at third edge");

    // R8: internal divider, slow and fast, pin toggling ignored
    src_sel = 1'b0; fast_mode = 1'b0;
    do_reset();
    for (int c = 0; c < 120; c++) begin
      ext_pin = c[2];
      @(negedge clk);
    end
    check(count, 16'd10, "R8 divide by 12");
    fast_mode = 1'b1;
    do_reset();
    repeat (120) @(negedge clk);
    check(count, 16'd20, "R8 divide by 6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule